// File: doc/BRIEF.md
# Process-Tagged Translation Buffer

This block keeps a small, fully associative set of recently used page translations. Every entry holds a virtual page number, the owning process identifier, a physical frame number and two permission flags: write allowed and user access allowed. A requester presents a page number, an offset, its process identifier, whether it is writing and whether it runs in user mode. In the same cycle the block answers with a translated physical address, or it raises a protection fault. Because entries carry the process identifier, translations from several processes can sit in the buffer together and survive a context switch.

When no entry matches, the block asks an external table walker for the mapping. It holds that request until the walker answers. It then installs the returned mapping, unless the walker reported a fault or software revoked the page while the request was outstanding. Software has two commands: one empties the whole buffer, and one removes a single page of a single process, for example after a page has been made read-only. The replacement slot is the lowest free entry. When no entry is free, a rotating pointer chooses the slot.

Top module: `ptag_tlb`

## Requirements
- R1: A lookup (`lk_valid`=1) reports `rsp_hit` in the same cycle when one valid entry holds both `lk_vpn` and `lk_pid` and the access is permitted. `rsp_paddr` is then the stored frame number in the upper bits, joined with `lk_off` in the lower OFF_W bits. With `lk_valid`=0, neither `rsp_hit` nor `rsp_prot_fault` is raised.
- R2: Entries with the same page number and different process identifiers coexist, and each resolves to its own frame.
- R3: A matching lookup reports `rsp_prot_fault` instead of `rsp_hit` when it writes to an entry whose write flag is 0, or when it is a user access to an entry whose user flag is 0.
- R4: A lookup that matches no entry, made while no refill is outstanding, raises `walk_req_valid` in the next cycle, carrying that page and process. The request stays high with a stable page until a cycle with `walk_rsp_valid`=1. The installed mapping hits from the cycle after that response.
- R5: A walker response with `walk_rsp_fault`=1 shows up in the same cycle as `rsp_walk_fault`, and nothing is installed.
- R6: A cycle with `flush_all`=1 leaves every entry invalid from the next cycle on.
- R7: A cycle with `inv_valid`=1 removes only the entry holding both `inv_vpn` and `inv_pid`. A lookup of that page and process in the very next cycle misses, and the same page of another process keeps hitting.
- R8: If, while a refill is outstanding, a flush or an invalidate naming the pending page and process arrives (up to and including the response cycle), that response is not installed. An invalidate naming a different process does not cancel the install.
- R9: An install goes to the lowest-numbered invalid entry. When all entries are valid, it goes to a rotating pointer that starts at entry 0 after reset and advances by one after each such replacement.
- R10: After reset, all entries are invalid and `walk_req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup present |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_off | input | OFF_W | Page offset, passed through |
| lk_pid | input | PID_W | Current process identifier |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is made in user mode |
| rsp_hit | output | 1 | Permitted translation found |
| rsp_prot_fault | output | 1 | Entry found but access not permitted |
| rsp_paddr | output | PFN_W+OFF_W | Translated physical address |
| walk_req_valid | output | 1 | Refill request to the table walker |
| walk_req_vpn | output | VPN_W | Page to be walked |
| walk_req_pid | output | PID_W | Process of the page to be walked |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_fault | input | 1 | Walker found no valid mapping |
| walk_rsp_pfn | input | PFN_W | Returned frame number |
| walk_rsp_w | input | 1 | Returned write permission |
| walk_rsp_u | input | 1 | Returned user permission |
| rsp_walk_fault | output | 1 | Walker fault passed to the requester |
| flush_all | input | 1 | Invalidate every entry |
| inv_valid | input | 1 | Invalidate one page of one process |
| inv_vpn | input | VPN_W | Page to invalidate |
| inv_pid | input | PID_W | Process of the page to invalidate |

## Verification
The hardest situation to reach from the ports is an invalidate or flush that lands while a refill is outstanding. The outcome only shows later, as whether the next lookup hits. The bench plays the walker itself. It holds the answer back for one cycle after the request appears, fires the command in that window, and only then answers. A fresh lookup must then miss and walk again, or hit when the invalidate named another process. Round-robin replacement is reached by flushing, filling all sixteen entries and probing which pages survive each further install.

// File: rtl/ptag_tlb_pkg.sv
package ptag_tlb_pkg;

   typedef enum logic [0:0] {
      RF_IDLE = 1'b0,
      RF_WAIT = 1'b1
   } refill_state_e;

   // true when the access may not use the cached mapping
   function automatic logic perm_violation(input logic is_write, input logic is_user,
                                           input logic may_write, input logic may_user);
      return (is_write && !may_write) || (is_user && !may_user);
   endfunction

endpackage

// File: rtl/ptag_tlb_store.sv
module ptag_tlb_store #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PID_W   = 8,
   parameter int PFN_W   = 20,
   parameter int IDX_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [VPN_W-1:0]   lk_vpn,
   input  logic [PID_W-1:0]   lk_pid,
   output logic               hit_any,
   output logic [PFN_W-1:0]   hit_pfn,
   output logic               hit_w,
   output logic               hit_u,
   output logic [ENTRIES-1:0] match_vec,
   output logic [ENTRIES-1:0] valid_vec,
   input  logic               flush,
   input  logic               inv_valid,
   input  logic [VPN_W-1:0]   inv_vpn,
   input  logic [PID_W-1:0]   inv_pid,
   input  logic               ins_en,
   input  logic [IDX_W-1:0]   ins_idx,
   input  logic [VPN_W-1:0]   ins_vpn,
   input  logic [PID_W-1:0]   ins_pid,
   input  logic [PFN_W-1:0]   ins_pfn,
   input  logic               ins_w,
   input  logic               ins_u
);

   logic [PFN_W-1:0] pfn_arr [ENTRIES];
   logic             w_arr   [ENTRIES];
   logic             u_arr   [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic             valid_q;
      logic [VPN_W-1:0] vpn_q;
      logic [PID_W-1:0] pid_q;
      logic [PFN_W-1:0] pfn_q;
      logic             w_q;
      logic             u_q;
      logic             sel;
      logic             kill;

      assign sel  = ins_en && (ins_idx == IDX_W'(e));
      assign kill = flush || (inv_valid && valid_q && vpn_q == inv_vpn && pid_q == inv_pid);

      // an install was already screened against invalidates by the refill unit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     valid_q <= 1'b0;
         else if (sel)   valid_q <= 1'b1;
         else if (kill)  valid_q <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            vpn_q <= ins_vpn;
            pid_q <= ins_pid;
            pfn_q <= ins_pfn;
            w_q   <= ins_w;
            u_q   <= ins_u;
         end
      end

      assign match_vec[e] = valid_q && (vpn_q == lk_vpn) && (pid_q == lk_pid);
      assign valid_vec[e] = valid_q;
      assign pfn_arr[e]   = pfn_q;
      assign w_arr[e]     = w_q;
      assign u_arr[e]     = u_q;
   end

   assign hit_any = |match_vec;

   always_comb begin
      hit_pfn = '0;
      hit_w   = 1'b0;
      hit_u   = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match_vec[i]) begin
            hit_pfn = hit_pfn | pfn_arr[i];
            hit_w   = hit_w | w_arr[i];
            hit_u   = hit_u | u_arr[i];
         end
      end
   end

endmodule

// File: rtl/ptag_tlb_victim.sv
module ptag_tlb_victim #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic               fill,
   output logic [IDX_W-1:0]   victim_idx
);

   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] free_idx;
   logic             any_free;

   always_comb begin
      free_idx = '0;
      any_free = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_vec[i]) begin
            free_idx = IDX_W'(i);
            any_free = 1'b1;
         end
      end
   end

   assign victim_idx = any_free ? free_idx : rr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (fill && !any_free) begin
         rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + IDX_W'(1);
      end
   end

endmodule

// File: rtl/ptag_tlb_refill.sv
module ptag_tlb_refill
   import ptag_tlb_pkg::*;
#(
   parameter int VPN_W = 20,
   parameter int PID_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic [PID_W-1:0] lk_pid,
   input  logic             lk_match,
   input  logic             walk_rsp_valid,
   input  logic             walk_rsp_fault,
   input  logic             flush,
   input  logic             inv_valid,
   input  logic [VPN_W-1:0] inv_vpn,
   input  logic [PID_W-1:0] inv_pid,
   output logic             walk_req_valid,
   output logic [VPN_W-1:0] pend_vpn,
   output logic [PID_W-1:0] pend_pid,
   output logic             install,
   output logic             walk_fault
);

   refill_state_e    state_q;
   logic [VPN_W-1:0] pend_vpn_q;
   logic [PID_W-1:0] pend_pid_q;
   logic             cancel_q;
   logic             start;
   logic             resp;
   logic             inv_hits_pend;
   logic             cancel_now;

   assign start         = (state_q == RF_IDLE) && lk_valid && !lk_match;
   assign resp          = (state_q == RF_WAIT) && walk_rsp_valid;
   assign inv_hits_pend = inv_valid && (inv_vpn == pend_vpn_q) && (inv_pid == pend_pid_q);
   assign cancel_now    = cancel_q || flush || inv_hits_pend;

   assign install        = resp && !walk_rsp_fault && !cancel_now;
   assign walk_fault     = resp && walk_rsp_fault;
   assign walk_req_valid = (state_q == RF_WAIT);
   assign pend_vpn       = pend_vpn_q;
   assign pend_pid       = pend_pid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= RF_IDLE;
         pend_vpn_q <= '0;
         pend_pid_q <= '0;
         cancel_q   <= 1'b0;
      end else begin
         unique case (state_q)
            RF_IDLE: begin
               if (start) begin
                  state_q    <= RF_WAIT;
                  pend_vpn_q <= lk_vpn;
                  pend_pid_q <= lk_pid;
                  cancel_q   <= 1'b0;
               end
            end
            RF_WAIT: begin
               if (resp) begin
                  state_q  <= RF_IDLE;
                  cancel_q <= 1'b0;
               end else if (cancel_now) begin
                  cancel_q <= 1'b1;
               end
            end
            default: state_q <= RF_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ptag_tlb.sv
module ptag_tlb
   import ptag_tlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int PID_W   = 8,
   parameter int OFF_W   = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   lk_valid,
   input  logic [VPN_W-1:0]       lk_vpn,
   input  logic [OFF_W-1:0]       lk_off,
   input  logic [PID_W-1:0]       lk_pid,
   input  logic                   lk_write,
   input  logic                   lk_user,
   output logic                   rsp_hit,
   output logic                   rsp_prot_fault,
   output logic [PFN_W+OFF_W-1:0] rsp_paddr,
   output logic                   walk_req_valid,
   output logic [VPN_W-1:0]       walk_req_vpn,
   output logic [PID_W-1:0]       walk_req_pid,
   input  logic                   walk_rsp_valid,
   input  logic                   walk_rsp_fault,
   input  logic [PFN_W-1:0]       walk_rsp_pfn,
   input  logic                   walk_rsp_w,
   input  logic                   walk_rsp_u,
   output logic                   rsp_walk_fault,
   input  logic                   flush_all,
   input  logic                   inv_valid,
   input  logic [VPN_W-1:0]       inv_vpn,
   input  logic [PID_W-1:0]       inv_pid
);

   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("ptag_tlb: ENTRIES must be at least 2");
   end
   if (VPN_W < 1 || PFN_W < 1 || PID_W < 1 || OFF_W < 1) begin : g_bad_width
      $error("ptag_tlb: every field width must be at least 1");
   end

   logic [ENTRIES-1:0] ent_valid;
   logic [ENTRIES-1:0] ent_match;
   logic               hit_any;
   logic [PFN_W-1:0]   hit_pfn;
   logic               hit_w;
   logic               hit_u;
   logic [IDX_W-1:0]   victim_idx;
   logic               install;
   logic [VPN_W-1:0]   pend_vpn;
   logic [PID_W-1:0]   pend_pid;
   logic               viol;

   ptag_tlb_store #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PID_W   (PID_W),
      .PFN_W   (PFN_W),
      .IDX_W   (IDX_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_vpn    (lk_vpn),
      .lk_pid    (lk_pid),
      .hit_any   (hit_any),
      .hit_pfn   (hit_pfn),
      .hit_w     (hit_w),
      .hit_u     (hit_u),
      .match_vec (ent_match),
      .valid_vec (ent_valid),
      .flush     (flush_all),
      .inv_valid (inv_valid),
      .inv_vpn   (inv_vpn),
      .inv_pid   (inv_pid),
      .ins_en    (install),
      .ins_idx   (victim_idx),
      .ins_vpn   (pend_vpn),
      .ins_pid   (pend_pid),
      .ins_pfn   (walk_rsp_pfn),
      .ins_w     (walk_rsp_w),
      .ins_u     (walk_rsp_u)
   );

   ptag_tlb_victim #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W)
   ) u_victim (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_vec  (ent_valid),
      .fill       (install),
      .victim_idx (victim_idx)
   );

   ptag_tlb_refill #(
      .VPN_W (VPN_W),
      .PID_W (PID_W)
   ) u_refill (
      .clk            (clk),
      .rst_n          (rst_n),
      .lk_valid       (lk_valid),
      .lk_vpn         (lk_vpn),
      .lk_pid         (lk_pid),
      .lk_match       (hit_any),
      .walk_rsp_valid (walk_rsp_valid),
      .walk_rsp_fault (walk_rsp_fault),
      .flush          (flush_all),
      .inv_valid      (inv_valid),
      .inv_vpn        (inv_vpn),
      .inv_pid        (inv_pid),
      .walk_req_valid (walk_req_valid),
      .pend_vpn       (pend_vpn),
      .pend_pid       (pend_pid),
      .install        (install),
      .walk_fault     (rsp_walk_fault)
   );

   assign viol           = perm_violation(lk_write, lk_user, hit_w, hit_u);
   assign rsp_hit        = lk_valid && hit_any && !viol;
   assign rsp_prot_fault = lk_valid && hit_any && viol;
   assign rsp_paddr      = {hit_pfn, lk_off};
   assign walk_req_vpn   = pend_vpn;
   assign walk_req_pid   = pend_pid;

endmodule

// File: rtl/ptag_tlb_chk.sv
module ptag_tlb_chk #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PID_W   = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic [VPN_W-1:0]   lk_vpn,
   input logic [PID_W-1:0]   lk_pid,
   input logic               rsp_hit,
   input logic               rsp_prot_fault,
   input logic               rsp_walk_fault,
   input logic               walk_req_valid,
   input logic [VPN_W-1:0]   walk_req_vpn,
   input logic [PID_W-1:0]   walk_req_pid,
   input logic               walk_rsp_valid,
   input logic               walk_rsp_fault,
   input logic               flush_all,
   input logic               inv_valid,
   input logic [VPN_W-1:0]   inv_vpn,
   input logic [PID_W-1:0]   inv_pid,
   input logic [ENTRIES-1:0] valid_vec,
   input logic [ENTRIES-1:0] match_vec
);

   p_single_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));

   p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> (!rsp_hit && !rsp_prot_fault));

   p_hit_or_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_hit && rsp_prot_fault));

   p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req_valid && !walk_rsp_valid) |=>
         (walk_req_valid && $stable(walk_req_vpn) && $stable(walk_req_pid)));

   p_fault_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_walk_fault |-> (walk_req_valid && walk_rsp_valid && walk_rsp_fault));

   p_fault_no_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_rsp_valid && walk_rsp_fault) |=>
         ($countones(valid_vec) <= $past($countones(valid_vec))));

   p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (valid_vec == '0));

   p_inv_next_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |=> !(rsp_hit && lk_vpn == $past(inv_vpn) && lk_pid == $past(inv_pid)));

endmodule

bind ptag_tlb ptag_tlb_chk #(
   .ENTRIES (ENTRIES),
   .VPN_W   (VPN_W),
   .PID_W   (PID_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .lk_valid       (lk_valid),
   .lk_vpn         (lk_vpn),
   .lk_pid         (lk_pid),
   .rsp_hit        (rsp_hit),
   .rsp_prot_fault (rsp_prot_fault),
   .rsp_walk_fault (rsp_walk_fault),
   .walk_req_valid (walk_req_valid),
   .walk_req_vpn   (walk_req_vpn),
   .walk_req_pid   (walk_req_pid),
   .walk_rsp_valid (walk_rsp_valid),
   .walk_rsp_fault (walk_rsp_fault),
   .flush_all      (flush_all),
   .inv_valid      (inv_valid),
   .inv_vpn        (inv_vpn),
   .inv_pid        (inv_pid),
   .valid_vec      (ent_valid),
   .match_vec      (ent_match)
);

// File: tb/ptag_tlb_test.sv
module ptag_tlb_test;

   localparam int ENTRIES = 16;
   localparam int VPN_W   = 20;
   localparam int PFN_W   = 20;
   localparam int PID_W   = 8;
   localparam int OFF_W   = 12;
   localparam int PA_W    = PFN_W + OFF_W;

   localparam int O_HIT      = 0;
   localparam int O_FILL     = 1;
   localparam int O_PROT     = 2;
   localparam int O_FILLPROT = 3;
   localparam int O_WFAULT   = 4;

   typedef struct packed {
      logic [19:0] vpn;
      logic [7:0]  pid;
      logic        wr;
      logic        us;
      logic [19:0] pfn;
      logic        w;
      logic        u;
      logic        wf;
      logic [2:0]  exp;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VT [NV] = '{
      '{20'h00010, 8'd1, 1'b0, 1'b0, 20'h00A10, 1'b1, 1'b1, 1'b0, 3'd1},
      '{20'h00010, 8'd1, 1'b1, 1'b1, 20'h00A10, 1'b1, 1'b1, 1'b0, 3'd0},
      '{20'h00010, 8'd2, 1'b0, 1'b0, 20'h00B10, 1'b0, 1'b1, 1'b0, 3'd1},
      '{20'h00010, 8'd2, 1'b1, 1'b1, 20'h00B10, 1'b0, 1'b1, 1'b0, 3'd2},
      '{20'h00010, 8'd1, 1'b0, 1'b1, 20'h00A10, 1'b1, 1'b1, 1'b0, 3'd0},
      '{20'h00020, 8'd1, 1'b0, 1'b1, 20'h00C20, 1'b1, 1'b0, 1'b0, 3'd3},
      '{20'h00020, 8'd1, 1'b0, 1'b0, 20'h00C20, 1'b1, 1'b0, 1'b0, 3'd0},
      '{20'h00030, 8'd1, 1'b0, 1'b0, 20'h00000, 1'b0, 1'b0, 1'b1, 3'd4},
      '{20'h00030, 8'd1, 1'b0, 1'b0, 20'h00000, 1'b0, 1'b0, 1'b1, 3'd4},
      '{20'h00030, 8'd1, 1'b1, 1'b0, 20'h00D30, 1'b1, 1'b1, 1'b0, 3'd1},
      '{20'h00030, 8'd1, 1'b1, 1'b1, 20'h00D30, 1'b1, 1'b1, 1'b0, 3'd0},
      '{20'h00020, 8'd1, 1'b1, 1'b0, 20'h00C20, 1'b1, 1'b0, 1'b0, 3'd0}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             lk_valid = 1'b0;
   logic [VPN_W-1:0] lk_vpn = '0;
   logic [OFF_W-1:0] lk_off = '0;
   logic [PID_W-1:0] lk_pid = '0;
   logic             lk_write = 1'b0;
   logic             lk_user = 1'b0;
   logic             rsp_hit;
   logic             rsp_prot_fault;
   logic [PA_W-1:0]  rsp_paddr;
   logic             walk_req_valid;
   logic [VPN_W-1:0] walk_req_vpn;
   logic [PID_W-1:0] walk_req_pid;
   logic             walk_rsp_valid = 1'b0;
   logic             walk_rsp_fault = 1'b0;
   logic [PFN_W-1:0] walk_rsp_pfn = '0;
   logic             walk_rsp_w = 1'b0;
   logic             walk_rsp_u = 1'b0;
   logic             rsp_walk_fault;
   logic             flush_all = 1'b0;
   logic             inv_valid = 1'b0;
   logic [VPN_W-1:0] inv_vpn = '0;
   logic [PID_W-1:0] inv_pid = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   ptag_tlb #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PFN_W   (PFN_W),
      .PID_W   (PID_W),
      .OFF_W   (OFF_W)
   ) uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .lk_valid       (lk_valid),
      .lk_vpn         (lk_vpn),
      .lk_off         (lk_off),
      .lk_pid         (lk_pid),
      .lk_write       (lk_write),
      .lk_user        (lk_user),
      .rsp_hit        (rsp_hit),
      .rsp_prot_fault (rsp_prot_fault),
      .rsp_paddr      (rsp_paddr),
      .walk_req_valid (walk_req_valid),
      .walk_req_vpn   (walk_req_vpn),
      .walk_req_pid   (walk_req_pid),
      .walk_rsp_valid (walk_rsp_valid),
      .walk_rsp_fault (walk_rsp_fault),
      .walk_rsp_pfn   (walk_rsp_pfn),
      .walk_rsp_w     (walk_rsp_w),
      .walk_rsp_u     (walk_rsp_u),
      .rsp_walk_fault (rsp_walk_fault),
      .flush_all      (flush_all),
      .inv_valid      (inv_valid),
      .inv_vpn        (inv_vpn),
      .inv_pid        (inv_pid)
   );

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   function automatic logic [OFF_W-1:0] off_of(input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid);
      return OFF_W'(vpn * 7 + pid);
   endfunction

   // starts and ends at a falling edge; plays the table walker
   task automatic access(input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid,
                         input logic wr, input logic us,
                         input logic [PFN_W-1:0] wpfn, input logic ww, input logic wu,
                         input logic wf, output int outc, output logic [PA_W-1:0] pa);
      int walks;
      walks = 0;
      outc  = -1;
      pa    = '0;
      lk_valid = 1'b1; lk_vpn = vpn; lk_pid = pid;
      lk_write = wr;   lk_user = us; lk_off = off_of(vpn, pid);
      for (int t = 0; t < 12 && outc < 0; t++) begin
         #1;
         if (rsp_hit) begin
            outc = (walks > 0) ? O_FILL : O_HIT;
            pa   = rsp_paddr;
         end else if (rsp_prot_fault) begin
            outc = (walks > 0) ? O_FILLPROT : O_PROT;
         end else if (walk_req_valid) begin
            if (walks == 0) chk("R4 request one cycle after miss", 64'(t), 64'd1);
            chk("R4 request page and process", 64'({walk_req_pid, walk_req_vpn}), 64'({pid, vpn}));
            walk_rsp_valid = 1'b1; walk_rsp_fault = wf;
            walk_rsp_pfn = wpfn;   walk_rsp_w = ww; walk_rsp_u = wu;
            walks++;
            #1;
            if (wf) begin
               chk("R5 walker fault passed through", 64'(rsp_walk_fault), 64'd1);
               outc = O_WFAULT;
               lk_valid = 1'b0;
            end
         end
         @(negedge clk);
         walk_rsp_valid = 1'b0;
         walk_rsp_fault = 1'b0;
      end
      lk_valid = 1'b0;
      if (outc < 0) outc = 7;
   endtask

   task automatic do_flush();
      flush_all = 1'b1;
      @(negedge clk);
      flush_all = 1'b0;
   endtask

   task automatic do_inv(input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid);
      inv_valid = 1'b1; inv_vpn = vpn; inv_pid = pid;
      @(negedge clk);
      inv_valid = 1'b0;
   endtask

   task automatic expect_access(input string what, input logic [VPN_W-1:0] vpn,
                                input logic [PID_W-1:0] pid, input logic [PFN_W-1:0] pfn,
                                input int exp);
      int o;
      logic [PA_W-1:0] pa;
      access(vpn, pid, 1'b0, 1'b0, pfn, 1'b1, 1'b1, 1'b0, o, pa);
      chk(what, 64'(o), 64'(exp));
      if (o == O_HIT || o == O_FILL)
         chk({what, " address"}, 64'(pa), 64'({pfn, off_of(vpn, pid)}));
   endtask

   // refill held open while a command arrives, then answered
   task automatic pend_with_cmd(input string what, input logic [VPN_W-1:0] vpn,
                                input logic [PID_W-1:0] pid, input logic use_flush,
                                input logic [PID_W-1:0] ipid, input int exp_after);
      lk_valid = 1'b1; lk_vpn = vpn; lk_pid = pid;
      lk_write = 1'b0; lk_user = 1'b0; lk_off = off_of(vpn, pid);
      @(negedge clk);
      lk_valid = 1'b0;
      #1;
      chk("R4 request raised", 64'(walk_req_valid), 64'd1);
      if (use_flush) flush_all = 1'b1;
      else begin
         inv_valid = 1'b1; inv_vpn = vpn; inv_pid = ipid;
      end
      @(negedge clk);
      flush_all = 1'b0; inv_valid = 1'b0;
      walk_rsp_valid = 1'b1; walk_rsp_fault = 1'b0;
      walk_rsp_pfn = 20'h0F000 + PFN_W'(vpn); walk_rsp_w = 1'b1; walk_rsp_u = 1'b1;
      @(negedge clk);
      walk_rsp_valid = 1'b0;
      expect_access(what, vpn, pid, 20'h0F000 + PFN_W'(vpn), exp_after);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int o;
      logic [PA_W-1:0] pa;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: empty after reset
      #1;
      chk("R10 no request after reset", 64'(walk_req_valid), 64'd0);
      lk_valid = 1'b1; lk_vpn = 20'h00010; lk_pid = 8'd1;
      #1;
      chk("R10 lookup after reset misses", 64'({rsp_hit, rsp_prot_fault}), 64'd0);
      lk_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);

      // table of lookups: R1 R2 R3 R4 R5
      for (int i = 0; i < NV; i++) begin
         access(VT[i].vpn, VT[i].pid, VT[i].wr, VT[i].us,
                VT[i].pfn, VT[i].w, VT[i].u, VT[i].wf, o, pa);
         chk($sformatf("R1 R2 R3 R5 vector %0d outcome", i), 64'(o), 64'(VT[i].exp));
         if (o == O_HIT || o == O_FILL)
            chk($sformatf("R1 vector %0d address", i), 64'(pa),
                64'({VT[i].pfn, off_of(VT[i].vpn, VT[i].pid)}));
      end

      // R1: no lookup, no answer, even for a cached page
      lk_vpn = 20'h00010; lk_pid = 8'd1; lk_valid = 1'b0;
      #1;
      chk("R1 quiet without lookup", 64'({rsp_hit, rsp_prot_fault}), 64'd0);
      @(negedge clk);

      // R7: single-page invalidate, lookup in the very next cycle
      do_inv(20'h00010, 8'd1);
      expect_access("R7 invalidated page misses next cycle", 20'h00010, 8'd1, 20'h00A10, O_FILL);
      do_inv(20'h00010, 8'd1);
      expect_access("R7 other process keeps its page", 20'h00010, 8'd2, 20'h00B10, O_HIT);

      // R6: flush removes everything
      do_flush();
      expect_access("R6 flushed page misses", 20'h00020, 8'd1, 20'h00C20, O_FILL);
      expect_access("R6 flushed other process misses", 20'h00030, 8'd1, 20'h00D30, O_FILL);

      // R8: commands landing during an outstanding refill
      pend_with_cmd("R8 matching invalidate cancels install", 20'h00040, 8'd1, 1'b0, 8'd1, O_FILL);
      pend_with_cmd("R8 other-process invalidate keeps install", 20'h00050, 8'd1, 1'b0, 8'd2, O_HIT);
      pend_with_cmd("R8 flush cancels install", 20'h00060, 8'd1, 1'b1, 8'd0, O_FILL);

      // R9: free slots first, then rotating pointer from entry 0
      do_flush();
      for (int i = 0; i < ENTRIES; i++)
         expect_access("R9 fill free entry", VPN_W'(20'h00100 + i), 8'd3, PFN_W'(20'h00200 + i), O_FILL);
      expect_access("R9 first replacement", 20'h00110, 8'd3, 20'h00210, O_FILL);
      expect_access("R9 entry 1 survives", 20'h00101, 8'd3, 20'h00201, O_HIT);
      expect_access("R9 entry 0 was replaced", 20'h00100, 8'd3, 20'h00200, O_FILL);
      expect_access("R9 pointer moved to entry 1", 20'h00101, 8'd3, 20'h00201, O_FILL);
      expect_access("R9 entry 3 survives", 20'h00103, 8'd3, 20'h00203, O_HIT);
      expect_access("R9 pointer moved to entry 2", 20'h00102, 8'd3, 20'h00202, O_FILL);

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule